// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a list of transfers held in an on-chip RAM, without processor help between transfers. The RAM has three regions indexed by the same entry number. The command region holds one byte per entry, the transmit region one data word per entry, and the receive region one data word per entry. Software fills the command and transmit words through a small CPU port, sets a first-entry pointer and a last-entry pointer, picks a clock divider and raises the run input.

On that rising edge the engine copies the first-entry pointer into its working pointer. For each entry it reads the command byte and the transmit word, drives the chip selects from the command byte, and shifts 16 bits out on MOSI while capturing 16 bits from MISO. It then stores the captured word in the receive region of the same entry, records the entry as completed, and moves to the next one. The walk wraps from the top entry to entry 0. After the last entry a completion flag is set, and an interrupt follows if enabled. A low level on the slave-select input while mastering is a mode fault: the current transfer is aborted and a flag is raised.

Top module: `spiq_master`

## Requirements
- R1: The CPU port writes region 0 (command, low 8 bits kept) and region 1 (transmit). A read of region 0, 1 or 2 (receive) returns that entry's contents, zero-extended, on `cpu_rdata` one clock after the request. CPU writes to region 2 leave it unchanged.
- R2: A rising edge of `run` while idle, with both flags clear, loads the working pointer from `start_ptr`. Entries then run in increasing index order up to and including `end_ptr`, wrapping from the top entry to entry 0 when `end_ptr` is below `start_ptr`.
- R3: Each transfer moves 16 bits MSB first in SPI mode 0. SCK idles low, MOSI changes only while SCK falls, and MISO is sampled as SCK rises. Each SCK half period lasts `clk_div`+1 clocks.
- R4: The word captured during an entry's transfer is written to that entry's receive word.
- R5: During an entry's transfer, `cs_n[k]` is low exactly when bit k of the command byte (bits 3:0) is 1. Afterwards all chip selects return high, unless command bit 4 is 1 and the entry is not the last one, in which case they stay as they are until the next entry drives them.
- R6: Command bit 5 inserts an idle gap of `GAP_CYC` clocks after that entry's transfer, before the next entry starts.
- R7: `cpt_ptr` holds the index of the most recently finished entry (0 after reset).
- R8: When the entry at `end_ptr` finishes, `done_flag` sets and the engine goes idle. `irq` equals `done_flag` AND `irq_en`. A one-clock pulse on `done_clr` clears the flag.
- R9: Dropping `run` lets the current entry finish and then stops the engine. No further entry runs and `done_flag` stays clear.
- R10: `ss_n` low sets `modf_flag`, aborts the transfer (SCK low, all chip selects high, engine idle), and blocks new starts until `modf_clr` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_region | input | 2 | Region select: 0 command, 1 transmit, 2 receive |
| cpu_idx | input | PW (5) | Entry index for CPU access |
| cpu_wdata | input | DW (16) | CPU write data |
| cpu_rdata | output | DW (16) | CPU read data, one clock after request |
| run | input | 1 | Engine run; rising edge starts a queue |
| irq_en | input | 1 | Interrupt enable |
| start_ptr | input | PW (5) | First entry of the queue |
| end_ptr | input | PW (5) | Last entry of the queue |
| clk_div | input | DIVW (8) | SCK half period minus one, in clocks |
| done_clr | input | 1 | Clears the completion flag |
| modf_clr | input | 1 | Clears the mode-fault flag |
| done_flag | output | 1 | Queue completed |
| modf_flag | output | 1 | Mode fault seen |
| irq | output | 1 | Completion interrupt |
| cpt_ptr | output | PW (5) | Index of the last finished entry |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | CS_W (4) | Active-low peripheral selects |
| ss_n | input | 1 | Slave-select input, low means mode fault |

## Verification
The assertions assume that `ss_n`, `miso` and the control inputs are synchronous to `clk`. They also assume that `start_ptr`, `end_ptr` and `clk_div` stay unchanged while a queue runs, and that the CPU does not write an entry the engine is about to read. The bench drives every input at falling clock edges and sets pointers and divider only between runs. It loads RAM only while the engine is idle and pulls `ss_n` low only in the mode-fault scenario. The slave model changes MISO on SCK falling edges so that the value is stable at each sampling rise.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
   // CPU port region codes
   localparam logic [1:0] RGN_CMD = 2'd0;
   localparam logic [1:0] RGN_TX  = 2'd1;
   localparam logic [1:0] RGN_RX  = 2'd2;

   // command byte layout
   localparam int CMD_W    = 8;
   localparam int CMD_HOLD = 4;   // keep selects low after the transfer
   localparam int CMD_GAP  = 5;   // idle gap after the transfer

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LOAD,
      SQ_LAUNCH,
      SQ_SHIFT,
      SQ_STORE,
      SQ_GAP
   } sq_state_t;
endpackage

// File: rtl/spiq_ram.sv
module spiq_ram
   import spiq_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int DW      = 16,
   parameter bit RD_REG  = 1'b1,
   localparam int PW     = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             cpu_we,
   input  logic [1:0]       cpu_region,
   input  logic [PW-1:0]    cpu_idx,
   input  logic [DW-1:0]    cpu_wdata,
   output logic [DW-1:0]    cpu_rdata,
   input  logic [PW-1:0]    eng_idx,
   output logic [CMD_W-1:0] eng_cmd,
   output logic [DW-1:0]    eng_tx,
   input  logic             eng_we,
   input  logic [PW-1:0]    eng_widx,
   input  logic [DW-1:0]    eng_wdata
);
   logic [CMD_W-1:0] cmd_mem [ENTRIES];
   logic [DW-1:0]    tx_mem  [ENTRIES];
   logic [DW-1:0]    rx_mem  [ENTRIES];
   logic [DW-1:0]    rd_mux;

   always_ff @(posedge clk) begin
      if (cpu_we && cpu_region == RGN_CMD) cmd_mem[cpu_idx] <= cpu_wdata[CMD_W-1:0];
      if (cpu_we && cpu_region == RGN_TX)  tx_mem[cpu_idx]  <= cpu_wdata;
      if (eng_we)                          rx_mem[eng_widx] <= eng_wdata;
      eng_cmd <= cmd_mem[eng_idx];
      eng_tx  <= tx_mem[eng_idx];
   end

   always_comb begin
      unique case (cpu_region)
         RGN_CMD: rd_mux = DW'(cmd_mem[cpu_idx]);
         RGN_TX:  rd_mux = tx_mem[cpu_idx];
         RGN_RX:  rd_mux = rx_mem[cpu_idx];
         default: rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) cpu_rdata <= rd_mux;
      end else begin : g_rd_comb
         assign cpu_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/spiq_shift.sv
module spiq_shift #(
   parameter int DW   = 16,
   parameter int DIVW = 8,
   localparam int BW  = $clog2(DW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            abort,
   input  logic [DW-1:0]   tx_word,
   input  logic [DIVW-1:0] clk_div,
   input  logic            miso,
   output logic            sck,
   output logic            mosi,
   output logic            done,
   output logic [DW-1:0]   rx_word
);
   logic            busy;
   logic [DIVW-1:0] tick_cnt;
   logic [BW-1:0]   bit_cnt;
   logic [DW-1:0]   tx_sh;
   logic [DW-1:0]   rx_sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         sck      <= 1'b0;
         done     <= 1'b0;
         tick_cnt <= '0;
         bit_cnt  <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            busy     <= 1'b0;
            sck      <= 1'b0;
            tick_cnt <= '0;
            bit_cnt  <= '0;
         end else if (start && !busy) begin
            busy     <= 1'b1;
            sck      <= 1'b0;
            tx_sh    <= tx_word;
            tick_cnt <= clk_div;
            bit_cnt  <= '0;
         end else if (busy) begin
            if (tick_cnt != '0) begin
               tick_cnt <= tick_cnt - 1'b1;
            end else begin
               tick_cnt <= clk_div;
               if (!sck) begin
                  sck   <= 1'b1;
                  rx_sh <= {rx_sh[DW-2:0], miso};
               end else begin
                  sck   <= 1'b0;
                  tx_sh <= {tx_sh[DW-2:0], 1'b0};
                  if (bit_cnt == BW'(DW-1)) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
         end
      end
   end

   assign mosi    = busy ? tx_sh[DW-1] : 1'b0;
   assign rx_word = rx_sh;

   // R3: the serial clock rests low whenever no word is in flight
   assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);
   // R3: MOSI never moves on the edge where SCK rises
   assert_mosi_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(mosi));
   // R3: SCK toggles only when the half-period counter expires
   assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !abort && tick_cnt != '0) |=> $stable(sck));
endmodule

// File: rtl/spiq_seq.sv
module spiq_seq
   import spiq_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int CS_W    = 4,
   parameter int GAP_CYC = 8,
   localparam int PW     = $clog2(ENTRIES),
   localparam int GW     = $clog2(GAP_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             irq_en,
   input  logic [PW-1:0]    start_ptr,
   input  logic [PW-1:0]    end_ptr,
   input  logic             done_clr,
   input  logic             modf_clr,
   input  logic             ss_n,
   output logic [PW-1:0]    eng_idx,
   input  logic [CMD_W-1:0] eng_cmd,
   output logic             shift_start,
   output logic             shift_abort,
   input  logic             shift_done,
   output logic             rx_we,
   output logic [CS_W-1:0]  cs_n,
   output logic             done_flag,
   output logic             modf_flag,
   output logic             irq,
   output logic [PW-1:0]    cpt_ptr
);
   sq_state_t     st;
   logic [PW-1:0] cur;
   logic [GW-1:0] gap_cnt;
   logic          run_q;
   logic          hold_q;
   logic          gap_q;
   logic          last;
   logic          entry_end;
   logic          unused_cmd_bits;

   assign last        = (cur == end_ptr);
   assign entry_end   = (st == SQ_STORE && !gap_q) || (st == SQ_GAP && gap_cnt == '0);
   assign shift_start = (st == SQ_LAUNCH);
   assign shift_abort = !ss_n;
   assign rx_we       = (st == SQ_STORE);
   assign eng_idx     = cur;
   assign irq         = done_flag & irq_en;
   assign unused_cmd_bits = ^eng_cmd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         cur       <= '0;
         cpt_ptr   <= '0;
         gap_cnt   <= '0;
         run_q     <= 1'b0;
         hold_q    <= 1'b0;
         gap_q     <= 1'b0;
         done_flag <= 1'b0;
         modf_flag <= 1'b0;
         cs_n      <= '1;
      end else begin
         run_q <= run;
         if (done_clr) done_flag <= 1'b0;
         if (modf_clr) modf_flag <= 1'b0;
         if (!ss_n) begin
            modf_flag <= 1'b1;
            st        <= SQ_IDLE;
            cs_n      <= '1;
         end else begin
            unique case (st)
               SQ_IDLE: if (run && !run_q && !done_flag && !modf_flag) begin
                  cur <= start_ptr;
                  st  <= SQ_LOAD;
               end
               SQ_LOAD: st <= SQ_LAUNCH;
               SQ_LAUNCH: begin
                  hold_q <= eng_cmd[CMD_HOLD];
                  gap_q  <= eng_cmd[CMD_GAP];
                  cs_n   <= ~eng_cmd[CS_W-1:0];
                  st     <= SQ_SHIFT;
               end
               SQ_SHIFT: if (shift_done) st <= SQ_STORE;
               SQ_STORE: begin
                  cpt_ptr <= cur;
                  if (!(hold_q && !last && run)) cs_n <= '1;
                  if (gap_q) begin
                     gap_cnt <= GW'(GAP_CYC - 1);
                     st      <= SQ_GAP;
                  end
               end
               SQ_GAP: gap_cnt <= gap_cnt - 1'b1;
               default: st <= SQ_IDLE;
            endcase
            if (entry_end) begin
               if (last) begin
                  done_flag <= 1'b1;
                  st        <= SQ_IDLE;
               end else if (!run) begin
                  st <= SQ_IDLE;
               end else begin
                  cur <= cur + 1'b1;
                  st  <= SQ_LOAD;
               end
            end
         end
      end
   end

   // R5: no select is driven while the engine sits idle
   assert_cs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_IDLE) |-> (cs_n == '1));
   // R2: the working pointer steps by one (with wrap) between entries
   assert_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_end && !last && run && ss_n) |=> (cur == PW'($past(cur) + 1'b1)));
   // R7: the completed pointer only moves when an entry is stored
   assert_cpt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st != SQ_STORE) |=> $stable(cpt_ptr));
   // R8: completion persists until software clears it
   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !done_clr) |=> done_flag);
   // R9: with run low, an entry's end returns the engine to idle
   assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_end && !run && ss_n) |=> (st == SQ_IDLE && !done_flag) || $past(last));
   // R10: a slave-select hit aborts and flags
   assert_modf_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_n |=> (st == SQ_IDLE && modf_flag));
endmodule

// File: rtl/spiq_master.sv
module spiq_master
   import spiq_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int DW      = 16,
   parameter int CS_W    = 4,
   parameter int DIVW    = 8,
   parameter int GAP_CYC = 8,
   parameter bit RD_REG  = 1'b1,
   localparam int PW     = $clog2(ENTRIES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_we,
   input  logic [1:0]      cpu_region,
   input  logic [PW-1:0]   cpu_idx,
   input  logic [DW-1:0]   cpu_wdata,
   output logic [DW-1:0]   cpu_rdata,
   input  logic            run,
   input  logic            irq_en,
   input  logic [PW-1:0]   start_ptr,
   input  logic [PW-1:0]   end_ptr,
   input  logic [DIVW-1:0] clk_div,
   input  logic            done_clr,
   input  logic            modf_clr,
   output logic            done_flag,
   output logic            modf_flag,
   output logic            irq,
   output logic [PW-1:0]   cpt_ptr,
   output logic            sck,
   output logic            mosi,
   input  logic            miso,
   output logic [CS_W-1:0] cs_n,
   input  logic            ss_n
);
   generate
      if (ENTRIES < 2 || (1 << PW) != ENTRIES) begin : g_bad_entries
         $error("spiq_master: ENTRIES must be a power of two, at least 2");
      end
      if (DW < CMD_W) begin : g_bad_dw
         $error("spiq_master: DW must hold a full command byte");
      end
      if (CS_W < 1 || CS_W > 4) begin : g_bad_cs
         $error("spiq_master: CS_W must be 1 to 4");
      end
      if (GAP_CYC < 1 || DIVW < 1) begin : g_bad_misc
         $error("spiq_master: GAP_CYC and DIVW must be at least 1");
      end
   endgenerate

   logic [PW-1:0]    eng_idx;
   logic [CMD_W-1:0] eng_cmd;
   logic [DW-1:0]    eng_tx;
   logic [DW-1:0]    rx_word;
   logic             rx_we;
   logic             shift_start;
   logic             shift_abort;
   logic             shift_done;

   spiq_ram #(.ENTRIES(ENTRIES), .DW(DW), .RD_REG(RD_REG)) u_ram (
      .clk        (clk),
      .cpu_we     (cpu_we),
      .cpu_region (cpu_region),
      .cpu_idx    (cpu_idx),
      .cpu_wdata  (cpu_wdata),
      .cpu_rdata  (cpu_rdata),
      .eng_idx    (eng_idx),
      .eng_cmd    (eng_cmd),
      .eng_tx     (eng_tx),
      .eng_we     (rx_we),
      .eng_widx   (eng_idx),
      .eng_wdata  (rx_word)
   );

   spiq_shift #(.DW(DW), .DIVW(DIVW)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (shift_start),
      .abort   (shift_abort),
      .tx_word (eng_tx),
      .clk_div (clk_div),
      .miso    (miso),
      .sck     (sck),
      .mosi    (mosi),
      .done    (shift_done),
      .rx_word (rx_word)
   );

   spiq_seq #(.ENTRIES(ENTRIES), .CS_W(CS_W), .GAP_CYC(GAP_CYC)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .irq_en      (irq_en),
      .start_ptr   (start_ptr),
      .end_ptr     (end_ptr),
      .done_clr    (done_clr),
      .modf_clr    (modf_clr),
      .ss_n        (ss_n),
      .eng_idx     (eng_idx),
      .eng_cmd     (eng_cmd),
      .shift_start (shift_start),
      .shift_abort (shift_abort),
      .shift_done  (shift_done),
      .rx_we       (rx_we),
      .cs_n        (cs_n),
      .done_flag   (done_flag),
      .modf_flag   (modf_flag),
      .irq         (irq),
      .cpt_ptr     (cpt_ptr)
   );
endmodule

// File: tb/spiq_master_test.sv
`timescale 1ns/1ps
module spiq_master_test;
   localparam int GAP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_we = 1'b0;
   logic [1:0]  cpu_region = 2'd0;
   logic [4:0]  cpu_idx = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        run = 1'b0, irq_en = 1'b0, done_clr = 1'b0, modf_clr = 1'b0;
   logic [4:0]  start_ptr = '0, end_ptr = '0;
   logic [7:0]  clk_div = 8'd1;
   logic        done_flag, modf_flag, irq, sck, mosi, miso;
   logic [4:0]  cpt_ptr;
   logic [3:0]  cs_n;
   logic        ss_n = 1'b1;

   int total = 0, bad = 0;

   spiq_master #(.GAP_CYC(GAP)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_region(cpu_region),
      .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .run(run), .irq_en(irq_en), .start_ptr(start_ptr), .end_ptr(end_ptr),
      .clk_div(clk_div), .done_clr(done_clr), .modf_clr(modf_clr),
      .done_flag(done_flag), .modf_flag(modf_flag), .irq(irq), .cpt_ptr(cpt_ptr),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .ss_n(ss_n));

   always #10 clk = ~clk;

   // SPI slave model: captures MOSI on rising SCK, shifts MISO on falling SCK
   int          nbits = 0, nx = 0, cs0_rel = 0;
   logic [15:0] cap = '0, slv_sh = '0;
   logic [15:0] reply [64];
   logic [15:0] mosi_log [64];
   logic [3:0]  cs_log [64];
   time         gap_log [64];
   time         rise_t = 0, fall_t = 0, per_t = 0;

   assign miso = slv_sh[15];

   always @(posedge sck) begin
      if (nbits == 0) begin
         gap_log[nx] = $time - fall_t;
         cs_log[nx]  = cs_n;
      end else begin
         per_t = $time - rise_t;
      end
      rise_t = $time;
      cap    = {cap[14:0], mosi};
      nbits  = nbits + 1;
      if (nbits == 16) begin
         mosi_log[nx] = cap;
         nx     = nx + 1;
         nbits  = 0;
         slv_sh = reply[nx];
      end
   end

   always @(negedge sck) begin
      fall_t = $time;
      if (nbits != 0) slv_sh = slv_sh << 1;
   end

   always @(posedge cs_n[0]) cs0_rel = cs0_rel + 1;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic mon_reset();
      nx = 0; nbits = 0; slv_sh = reply[0]; cs0_rel = 0;
   endtask

   task automatic cpu_wr(input logic [1:0] rg, input int idx, input logic [15:0] d);
      @(negedge clk); cpu_we = 1'b1; cpu_region = rg; cpu_idx = 5'(idx); cpu_wdata = d;
      @(negedge clk); cpu_we = 1'b0;
   endtask

   task automatic cpu_rd(input logic [1:0] rg, input int idx, output logic [15:0] d);
      @(negedge clk); cpu_region = rg; cpu_idx = 5'(idx);
      @(negedge clk); d = cpu_rdata;
   endtask

   task automatic go(input int s, input int e);
      @(negedge clk); run = 1'b0; start_ptr = 5'(s); end_ptr = 5'(e); mon_reset();
      @(negedge clk); run = 1'b1;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done_flag && n < 20000) begin @(negedge clk); n++; end
      check(done_flag == 1'b1, req, 32'(done_flag), 32'd1);
   endtask

   task automatic clear_done();
      @(negedge clk); done_clr = 1'b1; run = 1'b0;
      @(negedge clk); done_clr = 1'b0;
   endtask

   task automatic t_reset();
      check(done_flag == 1'b0 && modf_flag == 1'b0 && irq == 1'b0, "R8 reset flags",
            {29'd0, done_flag, modf_flag, irq}, 32'd0);
      check(cs_n == 4'hF && sck == 1'b0, "R5 reset pins", {27'd0, cs_n, sck}, 32'h1E);
      check(cpt_ptr == 5'd0, "R7 reset cpt", 32'(cpt_ptr), 32'd0);
   endtask

   task automatic t_queue();
      logic [15:0] d;
      logic [3:0]  pat [3];
      pat[0] = 4'h1; pat[1] = 4'h2; pat[2] = 4'hC;
      for (int i = 0; i < 3; i++) begin
         cpu_wr(2'd0, 2 + i, {12'h0, pat[i]});
         cpu_wr(2'd1, 2 + i, 16'hA5C3 ^ 16'(i * 16'h1111));
         reply[i] = 16'h8E71 + 16'(i * 16'h0203);
      end
      clk_div = 8'd1; irq_en = 1'b1;
      go(2, 4);
      wait_done("R8 queue done");
      check(nx == 3, "R2 entry count", 32'(nx), 32'd3);
      for (int i = 0; i < 3; i++) begin
         check(mosi_log[i] == (16'hA5C3 ^ 16'(i * 16'h1111)), "R2 R3 tx order",
               32'(mosi_log[i]), 32'(16'hA5C3 ^ 16'(i * 16'h1111)));
         check(cs_log[i] == ~pat[i], "R5 cs pattern", 32'(cs_log[i]), 32'(~pat[i]));
         cpu_rd(2'd2, 2 + i, d);
         check(d == reply[i], "R4 rx stored", 32'(d), 32'(reply[i]));
      end
      check(cpt_ptr == 5'd4, "R7 cpt last", 32'(cpt_ptr), 32'd4);
      check(irq == 1'b1, "R8 irq on", 32'(irq), 32'd1);
      check(cs_n == 4'hF, "R5 released at end", 32'(cs_n), 32'hF);
      clear_done();
      check(done_flag == 1'b0 && irq == 1'b0, "R8 clear", {30'd0, done_flag, irq}, 32'd0);
   endtask

   task automatic t_ram();
      logic [15:0] d;
      cpu_wr(2'd0, 9, 16'hC73A);
      cpu_rd(2'd0, 9, d);
      check(d == 16'h003A, "R1 cmd readback", 32'(d), 32'h3A);
      cpu_wr(2'd1, 9, 16'h1357);
      cpu_rd(2'd1, 9, d);
      check(d == 16'h1357, "R1 tx readback", 32'(d), 32'h1357);
      cpu_wr(2'd2, 2, 16'hFFFF);
      cpu_rd(2'd2, 2, d);
      check(d == reply[0], "R1 rx write ignored", 32'(d), 32'(reply[0]));
   endtask

   task automatic t_wrap();
      int ent [4];
      ent[0] = 30; ent[1] = 31; ent[2] = 0; ent[3] = 1;
      for (int i = 0; i < 4; i++) begin
         cpu_wr(2'd0, ent[i], 16'h0001);
         cpu_wr(2'd1, ent[i], 16'h3C00 + 16'(ent[i]));
         reply[i] = 16'h0F0F;
      end
      clk_div = 8'd0; irq_en = 1'b0;
      go(30, 1);
      wait_done("R2 wrap done");
      check(nx == 4, "R2 wrap count", 32'(nx), 32'd4);
      for (int i = 0; i < 4; i++)
         check(mosi_log[i] == 16'h3C00 + 16'(ent[i]), "R2 wrap order",
               32'(mosi_log[i]), 32'(16'h3C00 + 16'(ent[i])));
      check(cpt_ptr == 5'd1, "R7 wrap cpt", 32'(cpt_ptr), 32'd1);
      check(irq == 1'b0, "R8 irq masked", 32'(irq), 32'd0);
      clear_done();
   endtask

   task automatic t_period();
      logic [15:0] d;
      cpu_wr(2'd0, 5, 16'h0008);
      cpu_wr(2'd1, 5, 16'h6D29);
      reply[0] = 16'hB4E1;
      clk_div = 8'd3;
      go(5, 5);
      wait_done("R3 period done");
      check(per_t == 160, "R3 sck period", 32'(per_t), 32'd160);
      check(mosi_log[0] == 16'h6D29, "R3 msb first out", 32'(mosi_log[0]), 32'h6D29);
      cpu_rd(2'd2, 5, d);
      check(d == 16'hB4E1, "R3 msb first in", 32'(d), 32'hB4E1);
      clear_done();
   endtask

   task automatic t_hold();
      for (int i = 10; i < 13; i++) cpu_wr(2'd0, i, 16'h0011);
      clk_div = 8'd1;
      go(10, 12);
      wait_done("R5 hold done");
      check(cs0_rel == 1, "R5 hold keeps select", 32'(cs0_rel), 32'd1);
      check(cs_n == 4'hF, "R5 hold released on last", 32'(cs_n), 32'hF);
      clear_done();
      for (int i = 10; i < 13; i++) cpu_wr(2'd0, i, 16'h0001);
      go(10, 12);
      wait_done("R5 nohold done");
      check(cs0_rel == 3, "R5 no hold releases", 32'(cs0_rel), 32'd3);
      clear_done();
   endtask

   task automatic t_gap();
      time g0;
      cpu_wr(2'd0, 14, 16'h0001);
      cpu_wr(2'd0, 15, 16'h0001);
      clk_div = 8'd1;
      go(14, 15);
      wait_done("R6 base done");
      g0 = gap_log[1];
      clear_done();
      cpu_wr(2'd0, 14, 16'h0021);
      go(14, 15);
      wait_done("R6 gap done");
      check(gap_log[1] == g0 + GAP * 20, "R6 gap length", 32'(gap_log[1]), 32'(g0 + GAP * 20));
      clear_done();
   endtask

   task automatic t_stop();
      int n = 0;
      for (int i = 16; i < 20; i++) cpu_wr(2'd0, i, 16'h0001);
      clk_div = 8'd20;
      go(16, 19);
      while (nbits == 0 && n < 5000) begin @(negedge clk); n++; end
      run = 1'b0;
      repeat (3000) @(negedge clk);
      check(nx == 1, "R9 one entry only", 32'(nx), 32'd1);
      check(done_flag == 1'b0, "R9 no done", 32'(done_flag), 32'd0);
      check(cpt_ptr == 5'd16 && cs_n == 4'hF, "R9 stopped state",
            {23'd0, cpt_ptr, cs_n}, {23'd0, 5'd16, 4'hF});
   endtask

   task automatic t_modf();
      int n = 0, nb;
      for (int i = 20; i < 23; i++) cpu_wr(2'd0, i, 16'h0003);
      clk_div = 8'd20;
      go(20, 22);
      while (nbits < 3 && n < 5000) begin @(negedge clk); n++; end
      ss_n = 1'b0;
      @(negedge clk); ss_n = 1'b1;
      repeat (2) @(negedge clk);
      check(modf_flag == 1'b1, "R10 flag set", 32'(modf_flag), 32'd1);
      check(sck == 1'b0 && cs_n == 4'hF, "R10 abort pins", {27'd0, cs_n, sck}, 32'h1E);
      nb = nbits;
      run = 1'b0; @(negedge clk); run = 1'b1;
      repeat (1000) @(negedge clk);
      check(nbits == nb && nx == 0, "R10 start blocked", 32'(nbits), 32'(nb));
      @(negedge clk); modf_clr = 1'b1;
      @(negedge clk); modf_clr = 1'b0;
      check(modf_flag == 1'b0, "R10 clear", 32'(modf_flag), 32'd0);
      clk_div = 8'd1;
      go(20, 22);
      wait_done("R10 restart done");
      check(nx == 3, "R10 restart count", 32'(nx), 32'd3);
      clear_done();
   endtask

   initial begin
      for (int i = 0; i < 64; i++) reply[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_queue();
      t_ram();
      t_wrap();
      t_period();
      t_hold();
      t_gap();
      t_stop();
      t_modf();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #4000000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule